// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block owns the architectural state that a trap must preserve: the program counter, a processor status word (privilege, priority, condition codes), the active stack pointer, and two banked stack pointers, one for user code and one for supervisor code. When the surrounding core decides to take an interrupt, it hands the block a vector and a priority. The block then saves the status word and program counter on the supervisor stack and loads the service routine address from a vector table. When the core asks to return, the block pops both values back and restores the user stack pointer if the restored status word says user mode.

Both requests use a valid/ready handshake. A requester raises valid with its vector and priority, holds them steady, and keeps valid high until it sees ready high at a rising clock edge. Ready is low for the whole of a sequence, so a request that arrives while the block is busy simply waits. When both requests are valid in the same idle cycle, the interrupt is taken and the return request keeps waiting. The memory port uses plain strobes with no back-pressure. It expects a synchronous single-port memory: a write lands at the clock edge, and read data is valid on the cycle after the address. A return attempted in user mode is not executed. It raises a one-cycle privilege exception and runs an entry through a fixed exception vector at the current priority.

Top module: `intr_seq`

## Requirements
- R1: After reset, pc equals RESET_PC, psr equals RESET_PSR with only bits 15, 10:8 and 2:0 kept, sp equals RESET_SP, and busy, priv_exc and the memory strobes are low.
- R2: An entry started while psr bit 15 is 1 (user) copies sp into the banked user pointer and loads sp from the banked supervisor pointer before the first push.
- R3: An entry makes exactly two writes. First, sp is decremented and psr is written at the new sp. Then sp is decremented again and pc is written at that address. sp ends two below its starting supervisor value.
- R4: After an entry, psr bit 15 is 0, bits 10:8 hold the serviced priority, and bits 2:0 and all other bits are 0.
- R5: After an entry, pc holds the word read from address VEC_BASE + vector (0x0100 + vector by default), for every vector from 0x00 to 0xFF.
- R6: A return in supervisor mode reads pc from M[sp], then psr from M[sp+1], and leaves sp two higher. Only bits 15, 10:8 and 2:0 of the popped status word are kept.
- R7: If the popped psr has bit 15 set, sp is reloaded from the banked user pointer and the banked supervisor pointer takes the popped-to sp value.
- R8: A return requested in user mode pulses priv_exc for exactly the first busy cycle. It then performs an entry (R2 to R5) with vector EXC_VECTOR and with the priority that psr held before the request.
- R9: An entry started in supervisor mode pushes onto the current sp with no pointer swap.
- R10: busy is high for exactly 4 cycles after an entry is accepted and for exactly 3 cycles after a return is accepted. irq_ready and rti_ready are low whenever busy is high.
- R11: irq_ready equals not busy. rti_ready equals not busy and not irq_valid, so an interrupt wins over a return offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_valid | input | 1 | Take-interrupt request valid |
| irq_ready | output | 1 | Interrupt request accepted when high with irq_valid |
| irq_vector | input | 8 | Interrupt vector, held with irq_valid |
| irq_prio | input | 3 | Priority of the interrupt, held with irq_valid |
| rti_valid | input | 1 | Return-from-interrupt request valid |
| rti_ready | output | 1 | Return request accepted when high with rti_valid |
| busy | output | 1 | A sequence is in progress; pc not yet final |
| priv_exc | output | 1 | One-cycle pulse: return attempted in user mode |
| pc | output | 16 | Program counter |
| psr | output | 16 | Status word: bit 15 user, 10:8 priority, 2:0 condition codes |
| sp | output | 16 | Active stack pointer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low (with mem_en) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |

## Verification
An accepted request shows up at the first falling edge after the accepting rising edge. busy and priv_exc are due there. busy must then stay high through the fourth falling edge for an entry, or the third for a return, and be low at the next one. At that edge pc, psr and sp must already hold their final values. The bench steps a behavioural model by the same number of edges: it compares busy, both ready outputs and priv_exc at every falling edge, and it matches each write strobe seen at a falling edge against a queue of expected pushes in order.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int WORD_W  = 16;
  localparam int VEC_W   = 8;
  localparam int PRIO_W  = 3;
  localparam int PRIV_B  = 15;
  localparam int PRIO_LO = 8;
  localparam int CC_W    = 3;
  localparam logic [WORD_W-1:0] PSR_KEEP = 16'h8707;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PSR, ST_PUSH_PC, ST_VEC_RD, ST_VEC_LD,
    ST_POP_PC, ST_POP_PSR, ST_POP_END
  } seq_state_e;

  function automatic logic [WORD_W-1:0] psr_clean(input logic [WORD_W-1:0] v);
    return v & PSR_KEEP;
  endfunction

  function automatic logic [WORD_W-1:0] psr_entry(input logic [PRIO_W-1:0] p);
    logic [WORD_W-1:0] r;
    r = '0;
    r[PRIO_LO +: PRIO_W] = p;
    return r;
  endfunction
endpackage

// File: rtl/isq_ctrl.sv
module isq_ctrl
  import isq_pkg::*;
#(
  parameter logic [VEC_W-1:0] EXC_VECTOR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_valid,
  input  logic [VEC_W-1:0]   irq_vector,
  input  logic [PRIO_W-1:0]  irq_prio,
  input  logic               rti_valid,
  input  logic               psr_user,
  input  logic [PRIO_W-1:0]  psr_prio,
  output logic               irq_ready,
  output logic               rti_ready,
  output logic               entry_start,
  output seq_state_e         state,
  output logic [VEC_W-1:0]   vec_q,
  output logic [PRIO_W-1:0]  prio_q,
  output logic               priv_exc,
  output logic               busy
);
  logic idle, take_irq, take_rti;

  always_comb begin
    idle        = (state == ST_IDLE);
    irq_ready   = idle;
    rti_ready   = idle && !irq_valid;
    take_irq    = irq_valid && irq_ready;
    take_rti    = rti_valid && rti_ready;
    entry_start = take_irq || (take_rti && psr_user);
    busy        = !idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vec_q    <= '0;
      prio_q   <= '0;
      priv_exc <= 1'b0;
    end else begin
      priv_exc <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_irq) begin
            vec_q  <= irq_vector;
            prio_q <= irq_prio;
            state  <= ST_PUSH_PSR;
          end else if (take_rti) begin
            if (psr_user) begin
              vec_q    <= EXC_VECTOR;
              prio_q   <= psr_prio;
              priv_exc <= 1'b1;
              state    <= ST_PUSH_PSR;
            end else begin
              state <= ST_POP_PC;
            end
          end
        end
        ST_PUSH_PSR: state <= ST_PUSH_PC;
        ST_PUSH_PC:  state <= ST_VEC_RD;
        ST_VEC_RD:   state <= ST_VEC_LD;
        ST_VEC_LD:   state <= ST_IDLE;
        ST_POP_PC:   state <= ST_POP_PSR;
        ST_POP_PSR:  state <= ST_POP_END;
        ST_POP_END:  state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  // R8: the exception flag never lasts two cycles
  a_r8_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
    priv_exc |=> !priv_exc);

  // R11: with both requests offered while idle, the interrupt path starts
  a_r11_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && rti_valid && idle) |=> (state == ST_PUSH_PSR) && !priv_exc);

  // R10: a sequence never returns to idle from its first busy cycle
  a_r10_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

// File: rtl/isq_regs.sv
module isq_regs
  import isq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC  = 16'h3000,
  parameter logic [WORD_W-1:0] RESET_PSR = 16'h8002,
  parameter logic [WORD_W-1:0] RESET_SP  = 16'hF000,
  parameter logic [WORD_W-1:0] RESET_SSP = 16'h2FF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_state_e         state,
  input  logic               entry_start,
  input  logic [PRIO_W-1:0]  prio_q,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [WORD_W-1:0]  pc,
  output logic [WORD_W-1:0]  psr,
  output logic [WORD_W-1:0]  sp
);
  logic [WORD_W-1:0] usp_q, ssp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= RESET_PC;
      psr   <= psr_clean(RESET_PSR);
      sp    <= RESET_SP;
      usp_q <= RESET_SP;
      ssp_q <= RESET_SSP;
    end else begin
      if (entry_start && psr[PRIV_B]) begin
        usp_q <= sp;
        sp    <= ssp_q;
      end
      unique case (state)
        ST_PUSH_PSR, ST_PUSH_PC: sp <= sp - 1'b1;
        ST_VEC_RD:  psr <= psr_entry(prio_q);
        ST_VEC_LD:  pc  <= mem_rdata;
        ST_POP_PC:  sp  <= sp + 1'b1;
        ST_POP_PSR: begin
          pc <= mem_rdata;
          sp <= sp + 1'b1;
        end
        ST_POP_END: begin
          psr <= psr_clean(mem_rdata);
          if (mem_rdata[PRIV_B]) begin
            ssp_q <= sp;
            sp    <= usp_q;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: entering from user mode banks the old stack pointer
  a_r2_usp_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_start && psr[PRIV_B]) |=> usp_q == $past(sp));

  // R9: entering from supervisor mode leaves the stack pointer alone
  a_r9_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_start && !psr[PRIV_B]) |=> sp == $past(sp));

  // R4: status word after the vector read cycle
  a_r4_entry_psr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VEC_RD) |=> !psr[PRIV_B] && psr[CC_W-1:0] == '0
                            && psr[PRIO_LO +: PRIO_W] == $past(prio_q));

  // R6: each pop advances the stack pointer by one
  a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POP_PC) |=> sp == $past(sp) + 1'b1);
endmodule

// File: rtl/isq_memif.sv
module isq_memif
  import isq_pkg::*;
#(
  parameter logic [WORD_W-1:0] VEC_BASE = 16'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seq_state_e         state,
  input  logic [WORD_W-1:0]  sp,
  input  logic [WORD_W-1:0]  psr,
  input  logic [WORD_W-1:0]  pc,
  input  logic [VEC_W-1:0]   vec_q,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata
);
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_PSR: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = sp - 1'b1; mem_wdata = psr;
      end
      ST_PUSH_PC: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = sp - 1'b1; mem_wdata = pc;
      end
      ST_VEC_RD: begin
        mem_en = 1'b1;
        mem_addr = VEC_BASE + WORD_W'(vec_q);
      end
      ST_POP_PC, ST_POP_PSR: begin
        mem_en = 1'b1;
        mem_addr = sp;
      end
      default: ;
    endcase
  end

  // R3: the return address lands one word below the saved status word
  a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_PC) |-> mem_we && $past(mem_we)
                              && mem_addr == $past(mem_addr) - 1'b1);
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import isq_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC   = 16'h3000,
  parameter logic [WORD_W-1:0] RESET_PSR  = 16'h8002,
  parameter logic [WORD_W-1:0] RESET_SP   = 16'hF000,
  parameter logic [WORD_W-1:0] RESET_SSP  = 16'h2FF0,
  parameter logic [WORD_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [VEC_W-1:0]  EXC_VECTOR = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_valid,
  output logic                irq_ready,
  input  logic [VEC_W-1:0]    irq_vector,
  input  logic [PRIO_W-1:0]   irq_prio,
  input  logic                rti_valid,
  output logic                rti_ready,
  output logic                busy,
  output logic                priv_exc,
  output logic [WORD_W-1:0]   pc,
  output logic [WORD_W-1:0]   psr,
  output logic [WORD_W-1:0]   sp,
  output logic                mem_en,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata
);
  seq_state_e        state;
  logic              entry_start;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] prio_q;

  isq_ctrl #(.EXC_VECTOR(EXC_VECTOR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_prio(irq_prio),
    .rti_valid(rti_valid),
    .psr_user(psr[PRIV_B]), .psr_prio(psr[PRIO_LO +: PRIO_W]),
    .irq_ready(irq_ready), .rti_ready(rti_ready),
    .entry_start(entry_start), .state(state),
    .vec_q(vec_q), .prio_q(prio_q),
    .priv_exc(priv_exc), .busy(busy)
  );

  isq_regs #(
    .RESET_PC(RESET_PC), .RESET_PSR(RESET_PSR),
    .RESET_SP(RESET_SP), .RESET_SSP(RESET_SSP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state), .entry_start(entry_start),
    .prio_q(prio_q), .mem_rdata(mem_rdata),
    .pc(pc), .psr(psr), .sp(sp)
  );

  isq_memif #(.VEC_BASE(VEC_BASE)) u_memif (
    .clk(clk), .rst_n(rst_n), .state(state),
    .sp(sp), .psr(psr), .pc(pc), .vec_q(vec_q),
    .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R1: no memory traffic and no exception while idle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en && !priv_exc);

  // R10: pc changes only while a sequence runs or as it finishes
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(pc));
endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, irq_valid, irq_ready, rti_valid, rti_ready, busy, priv_exc;
  logic [7:0] irq_vector;
  logic [2:0] irq_prio;
  logic [15:0] pc, psr, sp, mem_addr, mem_wdata, mem_rdata;
  logic mem_en, mem_we;

  intr_seq #(.RESET_PSR(16'h8302)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_prio(irq_prio), .rti_valid(rti_valid),
    .rti_ready(rti_ready), .busy(busy), .priv_exc(priv_exc),
    .pc(pc), .psr(psr), .sp(sp), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [15:0] ram [0:4095];
  logic [15:0] mdl [0:4095];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[11:0]];
    end
  end

  int checks = 0, failures = 0;
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] m_pc, m_psr, m_sp, m_usp, m_ssp;
  logic [31:0] wq[$];
  int busy_left = 0;
  bit exp_exc = 0, run = 0;

  always @(negedge clk) begin
    if (run) begin
      logic [31:0] e;
      chk("R10 busy", {15'b0, busy}, {15'b0, busy_left > 0});
      chk("R10 irq_ready", {15'b0, irq_ready}, {15'b0, busy_left == 0});
      chk("R11 rti_ready", {15'b0, rti_ready}, {15'b0, (busy_left == 0) && !irq_valid});
      chk("R8 priv_exc", {15'b0, priv_exc}, {15'b0, exp_exc});
      exp_exc = 0;
      if (mem_en && mem_we) begin
        if (wq.size() == 0) chk("R3 unexpected write", mem_addr, 16'hxxxx);
        else begin
          e = wq.pop_front();
          chk("R3 push address", mem_addr, e[31:16]);
          chk("R3 push data", mem_wdata, e[15:0]);
        end
      end
      if (busy_left > 0) busy_left--;
    end
  end

  task automatic push_m(input logic [15:0] v);
    m_sp = m_sp - 16'd1;
    mdl[m_sp[11:0]] = v;
    wq.push_back({m_sp, v});
  endtask

  task automatic issue(input bit do_irq, input bit do_rti, input logic [7:0] v,
                       input logic [2:0] p, input string tpc, input string tpsr,
                       input string tsp);
    int n;
    bit exc;
    logic [7:0] vv;
    logic [2:0] pp;
    @(negedge clk); #1;
    irq_valid = do_irq; rti_valid = do_rti; irq_vector = v; irq_prio = p;
    exc = !do_irq && m_psr[15];
    if (do_irq || exc) begin
      vv = do_irq ? v : 8'h00;
      pp = do_irq ? p : m_psr[10:8];
      if (m_psr[15]) begin m_usp = m_sp; m_sp = m_ssp; end
      push_m(m_psr);
      push_m(m_pc);
      m_psr = {5'b0, pp, 8'b0};
      m_pc = mdl[12'h100 + {4'b0, vv}];
      n = 4;
    end else begin
      m_pc = mdl[m_sp[11:0]];
      m_sp = m_sp + 16'd1;
      m_psr = mdl[m_sp[11:0]] & 16'h8707;
      m_sp = m_sp + 16'd1;
      if (m_psr[15]) begin m_ssp = m_sp; m_sp = m_usp; end
      n = 3;
    end
    @(posedge clk);
    busy_left = n;
    exp_exc = exc;
    @(negedge clk); #1;
    irq_valid = 0; rti_valid = 0;
    repeat (n) @(negedge clk);
    #1;
    chk(tpc, pc, m_pc);
    chk(tpsr, psr, m_psr);
    chk(tsp, sp, m_sp);
    chk("R3 all pushes seen", 16'(wq.size()), 16'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin ram[i] = 16'h0; mdl[i] = 16'h0; end
    for (int i = 0; i < 256; i++) begin
      ram[12'h100 + i] = 16'h6000 + 16'(i * 16);
      mdl[12'h100 + i] = 16'h6000 + 16'(i * 16);
    end
    m_pc = 16'h3000; m_psr = 16'h8302; m_sp = 16'hF000;
    m_usp = 16'hF000; m_ssp = 16'h2FF0;
    irq_valid = 0; rti_valid = 0; irq_vector = 0; irq_prio = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset pc", pc, 16'h3000);
    chk("R1 reset psr", psr, 16'h8302);
    chk("R1 reset sp", sp, 16'hF000);
    chk("R1 reset busy", {15'b0, busy}, 16'd0);
    chk("R1 reset mem_en", {15'b0, mem_en}, 16'd0);
    run = 1;
    // user-mode interrupt: swap, two pushes, vector fetch
    issue(1, 0, 8'h80, 3'd4, "R5 pc", "R4 psr", "R2 sp");
    // nested, with a competing return request in the same cycle
    issue(1, 1, 8'h81, 3'd6, "R5 nested pc", "R4 nested psr", "R9 sp");
    // return staying in supervisor mode
    issue(0, 1, 8'h00, 3'd0, "R6 pc", "R6 psr", "R6 sp");
    // return to user mode restores the user pointer
    issue(0, 1, 8'h00, 3'd0, "R6 user pc", "R6 user psr", "R7 sp");
    // return attempted from user mode becomes an exception
    issue(0, 1, 8'h00, 3'd0, "R8 pc", "R8 psr", "R8 sp");
    issue(0, 1, 8'h00, 3'd0, "R6 exc pc", "R6 exc psr", "R7 exc sp");
    // highest vector and priority
    issue(1, 0, 8'hFF, 3'd7, "R5 top vector pc", "R4 top psr", "R2 again sp");
    issue(0, 1, 8'h00, 3'd0, "R6 last pc", "R6 last psr", "R7 last sp");
    run = 0;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule